// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is one timer channel that sits on a simple word-addressed register bus. A 16-bit divider turns the bus clock into ticks, and a 16-bit down-counter counts those ticks until the programmed period is used up. When the period runs out, a sticky status flag is set. In timer mode the channel either stops after one expiry or reloads and keeps running. An interrupt line follows the flag when it is enabled.

The same channel can instead guard the system as a watchdog. In that mode an expiry sends a one-clock reset request, so software must write a key byte before the period runs out to start the count again. Once the watchdog is armed, only one kind of mode write can disarm it: a complete 32-bit write that clears both the watchdog bit and the counter-enable bit together.

The control and status pins are plain level signals. There is no streaming data path, so there is no valid/ready handshake. The register interface takes a write in any clock cycle it is offered, and reads are combinational on `addr`.

Top module: `gp_timer_wdog`

## Requirements
- R1: After reset, all three registers read 0, and `irq`, `wdog_rst_req` and `gpio_oe` are 0.
- R2: The load register (word 1) holds the prescaler in bits 31:16 and the period in bits 15:0. After the write that sets the enable bit (mode bit 12), the first expiry sets status bit 0 on exactly the D×P-th rising clock edge, where D is the divisor and P the period.
- R3: A prescaler field of 0 divides by 65536 and a period field of 0 counts 65536 ticks. Any other value N divides or counts by N.
- R4: Clearing mode bit 12 stops counting, so no expiry follows. Setting it again restarts from a full prescale and period.
- R5: With mode bit 10 clear the timer expires once and stops. With it set, the timer reloads and expires again every D×P edges.
- R6: Status (word 2) bit 0 is sticky and is cleared by writing 1 to it in byte lane 0. Writing 0 leaves it set. `irq` equals status bit 0 AND mode bit 8, and it is forced to 0 while mode bit 15 is set.
- R7: With mode bits 15 and 12 set, an expiry sets status bit 0 and drives `wdog_rst_req` high for exactly one clock. The expiry happens only once, whatever bit 10 says, and `irq` stays 0.
- R8: While the watchdog is active, a write to the mode word with byte lane 3 enabled and data 0xA5 in bits 31:24 restarts the prescale and period from full. Any other value in that byte has no effect. Bits 31:24 always read as 0.
- R9: While the watchdog is active, bits 15 and 12 keep their value of 1 on every mode write except a 4-lane write whose data has bits 15 and 12 both 0. The other fields of such writes still take effect.
- R10: Mode bits 5:4 drive the pin: 2'b10 gives `gpio_oe`=1 and `gpio_out`=0, 2'b11 gives `gpio_oe`=1 and `gpio_out`=1, and any other value gives `gpio_oe`=0.
- R11: The mode word (word 0) stores only bits 2:0 (function select), 5:4, 8, 10, 12 and 15, and reads back those bits. The load word reads back as written. Writes honour `byte_en`. Any write to the load word restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word select: 0 mode, 1 load, 2 status |
| wdata | input | 32 | Write data |
| byte_en | input | 4 | Byte lane enables for the write |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Timer interrupt, level |
| wdog_rst_req | output | 1 | One-clock reset request on watchdog expiry |
| gpio_out | output | 1 | Pin drive value |
| gpio_oe | output | 1 | Pin drive enable |

## Verification
The assertions check the following on every cycle:
- the prescale counter never leaves the range of the current divisor;
- an armed period counter never holds zero;
- every expiry reaches the status flag on the next edge;
- the reset request never lasts two cycles;
- an active watchdog survives every write other than the full disarming one.

Some behaviour can only be shown by the bench's scenarios, because it depends on counting whole periods. This covers:
- the exact expiry edge for D×P;
- the 65536 cases for a zero prescaler or zero period;
- one-shot silence after expiry against the steady reload of continuous mode;
- a key write pushing the deadline out while a wrong byte does not;
- the pin encoding and the readback masks.

// File: rtl/gtw_pkg.sv
package gtw_pkg;
  localparam int DATA_W   = 32;
  localparam int MB_WDOG  = 15;
  localparam int MB_EN    = 12;
  localparam int MB_CONT  = 10;
  localparam int MB_IRQ   = 8;
  localparam int MB_PINHI = 5;
  localparam int MB_PINLO = 4;
  localparam logic [DATA_W-1:0] MODE_KEEP = 32'h0000_9537;
  localparam logic [7:0] SERVICE_KEY = 8'hA5;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gtw_prescaler.sv
module gtw_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [PS_W-1:0] div_val,
  output logic            tick
);
  localparam int CW = PS_W + 1;
  localparam logic [CW-1:0] FULL_DIV = CW'(1) << PS_W;

  logic [CW-1:0] div_eff;
  logic [CW-1:0] cnt_q;

  // zero in the field means the widest division
  assign div_eff = (div_val == '0) ? FULL_DIV : {1'b0, div_val};
  assign tick    = run && !restart && (cnt_q == div_eff - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= tick ? '0 : cnt_q + CW'(1);
  end

  assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_eff)
    else $error("prescale count out of range");
endmodule

// File: rtl/gtw_period.sv
module gtw_period #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             stop,
  input  logic             tick,
  input  logic             cont,
  input  logic [PER_W-1:0] period_val,
  output logic             armed,
  output logic             expire
);
  localparam int CW = PER_W + 1;
  localparam logic [CW-1:0] FULL_PER = CW'(1) << PER_W;

  logic [CW-1:0] load_val;
  logic [CW-1:0] rem_q;

  assign load_val = (period_val == '0) ? FULL_PER : {1'b0, period_val};
  assign expire   = tick && armed && !restart && (rem_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      rem_q <= load_val;
      armed <= 1'b1;
    end else if (stop) begin
      armed <= 1'b0;
    end else if (tick && armed) begin
      if (rem_q == CW'(1)) begin
        if (cont) rem_q <= load_val;
        else      armed <= 1'b0;
      end else begin
        rem_q <= rem_q - CW'(1);
      end
    end
  end

  assert_rem_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rem_q != '0))
    else $error("armed with empty period count");
endmodule

// File: rtl/gtw_regs.sv
module gtw_regs
  import gtw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        byte_en,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] load_q,
  output logic              restart,
  output logic              irq,
  output logic              wdog_rst_req,
  output logic              gpio_out,
  output logic              gpio_oe
);
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] mode_merge, mode_next, load_next;
  logic [3:0]        stat_q, stat_next;
  logic              mode_wr, load_wr, stat_wr;
  logic              wdog_active, full_disarm, service, en_rise;
  reg_sel_e          sel;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{byte_en[b]}};
  end

  assign sel         = reg_sel_e'(addr);
  assign mode_wr     = wr_en && (sel == SEL_MODE);
  assign load_wr     = wr_en && (sel == SEL_LOAD);
  assign stat_wr     = wr_en && (sel == SEL_STAT);
  assign wdog_active = mode_q[MB_WDOG] && mode_q[MB_EN];
  assign full_disarm = (byte_en == 4'hF) && !wdata[MB_WDOG] && !wdata[MB_EN];
  assign service     = mode_wr && byte_en[3] && wdog_active &&
                       (wdata[31:24] == SERVICE_KEY);

  always_comb begin
    mode_merge = ((mode_q & ~lane_mask) | (wdata & lane_mask)) & MODE_KEEP;
    mode_next  = mode_merge;
    if (wdog_active && !full_disarm) begin
      mode_next[MB_WDOG] = 1'b1;
      mode_next[MB_EN]   = 1'b1;
    end
  end

  assign load_next = (load_q & ~lane_mask) | (wdata & lane_mask);
  assign en_rise   = mode_wr && !mode_q[MB_EN] && mode_next[MB_EN];
  assign restart   = en_rise || load_wr || service;

  always_comb begin
    stat_next = stat_q;
    if (stat_wr && byte_en[0]) stat_next = stat_q & ~wdata[3:0];
    if (expire) stat_next[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= '0;
      load_q       <= '0;
      stat_q       <= '0;
      wdog_rst_req <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_next;
      if (load_wr) load_q <= load_next;
      stat_q       <= stat_next;
      wdog_rst_req <= expire && wdog_active;
    end
  end

  assign irq      = stat_q[0] && mode_q[MB_IRQ] && !mode_q[MB_WDOG];
  assign gpio_oe  = mode_q[MB_PINHI];
  assign gpio_out = mode_q[MB_PINHI] && mode_q[MB_PINLO];

  always_comb begin
    case (sel)
      SEL_MODE: rdata = mode_q;
      SEL_LOAD: rdata = load_q;
      SEL_STAT: rdata = {28'd0, stat_q};
      default:  rdata = '0;
    endcase
  end

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req)
    else $error("reset request longer than one clock");

  assert_wdog_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_active && !(mode_wr && full_disarm)) |=> wdog_active)
    else $error("watchdog dropped without full disarm");

  assert_expiry_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q[0])
    else $error("expiry not recorded in status");
endmodule

// File: rtl/gp_timer_wdog.sv
module gp_timer_wdog
  import gtw_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int PER_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  byte_en,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wdog_rst_req,
  output logic        gpio_out,
  output logic        gpio_oe
);
  localparam int PS_LSB = PER_W;

  logic [DATA_W-1:0] mode_q, load_q;
  logic restart, tick, armed, expire, run, cont;

  gtw_regs u_regs (
    .clk, .rst_n, .wr_en, .addr, .wdata, .byte_en, .expire,
    .rdata, .mode_q, .load_q, .restart, .irq, .wdog_rst_req,
    .gpio_out, .gpio_oe
  );

  assign run  = mode_q[MB_EN] && armed;
  assign cont = mode_q[MB_CONT] && !mode_q[MB_WDOG];

  gtw_prescaler #(.PS_W(PS_W)) u_pre (
    .clk, .rst_n, .restart, .run,
    .div_val(load_q[PS_LSB +: PS_W]),
    .tick
  );

  gtw_period #(.PER_W(PER_W)) u_per (
    .clk, .rst_n, .restart,
    .stop(!mode_q[MB_EN]),
    .tick, .cont,
    .period_val(load_q[PER_W-1:0]),
    .armed, .expire
  );
endmodule

// File: tb/test_gp_timer_wdog.sv
module test_gp_timer_wdog;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [3:0] byte_en = '0;
  logic [31:0] rdata;
  logic irq, wdog_rst_req, gpio_out, gpio_oe;
  int checks = 0, errors = 0;

  localparam logic [31:0] EN = 32'h1000, CONT = 32'h0400, IE = 32'h0100, WD = 32'h8000;

  always #5 clk = ~clk;

  gp_timer_wdog i_gp_timer_wdog (.clk, .rst_n, .wr_en, .addr, .wdata, .byte_en,
    .rdata, .irq, .wdog_rst_req, .gpio_out, .gpio_oe);

  function automatic int span(input int ps, input int per);
    return ((ps == 0) ? 65536 : ps) * ((per == 0) ? 65536 : per);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; addr = a; wdata = d; byte_en = be;
    @(negedge clk);
    wr_en = 1'b0; byte_en = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expiry_run(input int ps, input int per, input bit cont, input string tag);
    logic [31:0] v;
    int n;
    n = span(ps, per);
    wr(2'd1, {ps[15:0], per[15:0]}, 4'hF);
    wr(2'd0, EN | (cont ? CONT : 32'h0), 4'hF);
    waitn(n - 1);
    rd(2'd2, v); chk({tag, " before expiry"}, v, 32'h0);
    waitn(1);
    rd(2'd2, v); chk({tag, " at expiry"}, v, 32'h1);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pulses;
    void'($urandom(32'h5eed_1234));
    waitn(2);
    rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 mode", v, 0);
    rd(2'd1, v); chk("R1 load", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 outputs", {irq, wdog_rst_req, gpio_oe}, 0);

    // R11 readback masks and byte lanes
    wr(2'd0, 32'hFFFF_6C27, 4'hF);
    rd(2'd0, v); chk("R11 mode mask", v, 32'h0000_0427);
    wr(2'd1, 32'h1234_5678, 4'hF);
    wr(2'd1, 32'hAAAA_AA9C, 4'b0001);
    rd(2'd1, v); chk("R11 load byte lane", v, 32'h1234_569C);
    // R10 pin encoding (bits 5:4 = 2'b10 now)
    chk("R10 drive low", {gpio_oe, gpio_out}, 2'b10);
    wr(2'd0, 32'h30, 4'hF);
    chk("R10 drive high", {gpio_oe, gpio_out}, 2'b11);
    wr(2'd0, 32'h10, 4'hF);
    chk("R10 released", gpio_oe, 1'b0);
    wr(2'd0, 32'h0, 4'hF);

    // R2 directed timing
    expiry_run(3, 4, 1'b0, "R2 ps3 per4");
    // R3 zero fields
    expiry_run(0, 1, 1'b0, "R3 prescale zero");
    expiry_run(1, 0, 1'b0, "R3 period zero");

    // R5 one-shot stays silent after expiry
    wr(2'd1, {16'd2, 16'd3}, 4'hF);
    wr(2'd0, EN, 4'hF);
    waitn(6);
    wr(2'd2, 32'h1, 4'hF);
    waitn(30);
    rd(2'd2, v); chk("R5 one-shot no refire", v, 0);
    wr(2'd0, 32'h0, 4'hF);
    // R5 continuous refires
    wr(2'd0, EN | CONT, 4'hF);
    waitn(6);
    rd(2'd2, v); chk("R5 cont first", v, 1);
    wr(2'd2, 32'h1, 4'hF);
    waitn(4);
    rd(2'd2, v); chk("R5 cont between", v, 0);
    waitn(1);
    rd(2'd2, v); chk("R5 cont second", v, 1);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);

    // R4 stop and restart
    wr(2'd1, {16'd3, 16'd4}, 4'hF);
    wr(2'd0, EN, 4'hF);
    waitn(4);
    wr(2'd0, 32'h0, 4'hF);
    waitn(30);
    rd(2'd2, v); chk("R4 stopped", v, 0);
    wr(2'd0, EN, 4'hF);
    waitn(11);
    rd(2'd2, v); chk("R4 restart full before", v, 0);
    waitn(1);
    rd(2'd2, v); chk("R4 restart full at", v, 1);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);

    // R6 irq and W1C
    wr(2'd1, {16'd1, 16'd5}, 4'hF);
    wr(2'd0, EN | IE, 4'hF);
    waitn(4);
    chk("R6 irq low before", irq, 0);
    waitn(1);
    chk("R6 irq high", irq, 1);
    wr(2'd2, 32'h0, 4'hF);
    chk("R6 write zero keeps", irq, 1);
    wr(2'd2, 32'h1, 4'hF);
    chk("R6 W1C clears", irq, 0);
    wr(2'd0, 32'h0, 4'hF);

    // R7 watchdog pulse, single shot, no irq
    wr(2'd1, {16'd2, 16'd5}, 4'hF);
    wr(2'd0, WD | EN | IE | CONT, 4'hF);
    waitn(9);
    chk("R7 no req early", wdog_rst_req, 0);
    waitn(1);
    chk("R7 req pulse", wdog_rst_req, 1);
    rd(2'd2, v); chk("R7 status set", v, 1);
    chk("R7 irq masked", irq, 0);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      waitn(1);
      if (wdog_rst_req) pulses++;
    end
    chk("R7 single pulse", pulses, 0);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);

    // R8 key service pushes deadline
    wr(2'd0, WD | EN, 4'hF);
    waitn(6);
    wr(2'd0, 32'hA500_0000, 4'b1000);
    rd(2'd0, v); chk("R8 key byte reads zero", v, WD | EN);
    waitn(9);
    chk("R8 serviced no req", wdog_rst_req, 0);
    waitn(1);
    chk("R8 serviced req later", wdog_rst_req, 1);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);
    // R8 wrong byte has no effect
    wr(2'd0, WD | EN, 4'hF);
    waitn(6);
    wr(2'd0, 32'h5A00_0000, 4'b1000);
    waitn(2);
    chk("R8 wrong key no reload pre", wdog_rst_req, 0);
    waitn(1);
    chk("R8 wrong key expires", wdog_rst_req, 1);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);

    // R9 lock
    wr(2'd1, {16'd100, 16'd100}, 4'hF);
    wr(2'd0, WD | EN, 4'hF);
    wr(2'd0, 32'h30, 4'b0001);
    rd(2'd0, v); chk("R9 other field applied", v, WD | EN | 32'h30);
    chk("R9 pin via locked write", gpio_out, 1);
    wr(2'd0, 32'h0, 4'b0011);
    rd(2'd0, v); chk("R9 partial write", v, WD | EN);
    wr(2'd0, EN, 4'hF);
    rd(2'd0, v); chk("R9 keep on en only", v, WD | EN);
    wr(2'd0, WD, 4'hF);
    rd(2'd0, v); chk("R9 keep on wd only", v, WD | EN);
    wr(2'd0, 32'h0, 4'hF);
    rd(2'd0, v); chk("R9 full disarm", v, 0);

    // R2 random timing
    for (int k = 0; k < 16; k++) begin
      int ps, per;
      ps  = 1 + int'($urandom_range(5));
      per = 1 + int'($urandom_range(7));
      expiry_run(ps, per, 1'($urandom_range(1)), "R2 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule